// File: doc/BRIEF.md
# Memory Access Point Arbitration Controller

This controller sits where the on-chip circuit-switched network meets one off-chip memory module. Cores reach the module in two ways. A core asks for a read with a small control message. A core starts a write by sending a path-setup that arrives at the controller. Only one transaction owns the module at any time. Reads that cannot start at once wait in an internal first-in first-out queue. Writes that cannot start at once are refused, and the core retries later.

For a read, the controller drives a two-bit selector for the local data switch and opens the return circuit to the core itself. It retries that circuit until the network accepts it, then starts the command sequencer. Because it knows the sequencer latency and the burst length, it closes the read with a teardown in the cycle the data ends. For a write, the controller starts the sequencer first and waits for the sequencer's done. It then turns the switch toward the core and acknowledges the path. The write lasts until the writing core sends a teardown.

Top module: `map_arbiter`

## Requirements
- R1: While and right after reset, `sw_sel` is 00 and `msg_out_valid`, `blk_valid` and `seq_start` are low.
- R2: Reads are served one at a time in arrival order. A read accepted while another transaction runs is held and started later, and each setup and teardown carries that read's core number in `msg_out_core`.
- R3: A read request (`msg_in_kind` 00) that arrives while the queue already holds QDEPTH entries is answered in the same cycle with `blk_valid` high and `blk_core` equal to the requester, and it is dropped. The queue is judged full even in a cycle when an entry leaves it.
- R4: A write setup (`msg_in_kind` 01) is accepted only when the controller is idle and the queue is empty. In any other cycle it is answered in the same cycle with `blk_valid` and is not stored. This includes the cycle in which a read sends its teardown.
- R5: A read starts with exactly one cycle of `sw_sel` = 01 (controller to module). It then moves to `sw_sel` = 10 (module to core) with a setup message (`msg_out_kind` 01) in that first cycle.
- R6: After a setup, the controller waits for `path_resp_valid`. A refusal (`path_resp_ok` low) causes a new setup in the next cycle. An acceptance causes `seq_start` with `seq_write` low in the next cycle, and never earlier.
- R7: A read sends a teardown (`msg_out_kind` 11) exactly SEQ_LAT plus `seq_len` cycles after its `seq_start` cycle, and the transaction ends there.
- R8: An accepted write raises `seq_start` with `seq_write` high, and `sw_sel` = 01, in the next cycle. `sw_sel` stays 01 until `seq_done` is seen. In the following cycle `sw_sel` becomes 11 (core to module) and a one-cycle ack (`msg_out_kind` 10) is sent.
- R9: A write ends only on a teardown (`msg_in_kind` 10) from the writing core. A teardown from any other core, or a teardown outside a write, has no effect.
- R10: When a transaction ends, the controller spends one cycle with `sw_sel` = 00. It then starts the oldest queued read if there is one, and otherwise stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_in_valid | input | 1 | Incoming control message present |
| msg_in_kind | input | 2 | 00 read request, 01 write setup, 10 teardown, 11 ignored |
| msg_in_core | input | CORE_W | Sending core |
| msg_in_addr | input | ADDR_W | Start address of the transaction |
| msg_in_len | input | LEN_W | Burst length |
| msg_out_valid | output | 1 | Outgoing controller message present |
| msg_out_kind | output | 2 | 01 setup, 10 ack, 11 teardown |
| msg_out_core | output | CORE_W | Destination core |
| blk_valid | output | 1 | Path-blocked answer to the incoming message |
| blk_core | output | CORE_W | Core that is refused |
| path_resp_valid | input | 1 | Network answer to a setup |
| path_resp_ok | input | 1 | 1 accepted, 0 refused |
| sw_sel | output | 2 | 00 idle, 01 controller-module, 10 module-core, 11 core-module |
| seq_start | output | 1 | One-cycle start of the command sequencer |
| seq_write | output | 1 | Transaction is a write |
| seq_addr | output | ADDR_W | Address for the sequencer |
| seq_len | output | LEN_W | Burst length for the sequencer |
| seq_done | input | 1 | Sequencer finished the write commands |

## Verification
Two things can happen in the same cycle: a write setup that reaches the controller, and the read teardown that frees the module. The bench waits until its own model expects the teardown and injects the write in exactly that cycle. It expects both the teardown and the refusal on their separate ports in that cycle. A read pushed into the queue while the idle controller pops another read is a second such pair, and a burst of reads against a full queue covers it. A behavioural model, run every cycle, decides each expected output.

// File: rtl/map_arbiter.sv
module map_arbiter #(
  parameter int CORE_W  = 6,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 8,
  parameter int QDEPTH  = 4,
  parameter int SEQ_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_in_valid,
  input  logic [1:0]        msg_in_kind,
  input  logic [CORE_W-1:0] msg_in_core,
  input  logic [ADDR_W-1:0] msg_in_addr,
  input  logic [LEN_W-1:0]  msg_in_len,
  output logic              msg_out_valid,
  output logic [1:0]        msg_out_kind,
  output logic [CORE_W-1:0] msg_out_core,
  output logic              blk_valid,
  output logic [CORE_W-1:0] blk_core,
  input  logic              path_resp_valid,
  input  logic              path_resp_ok,
  output logic [1:0]        sw_sel,
  output logic              seq_start,
  output logic              seq_write,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [LEN_W-1:0]  seq_len,
  input  logic              seq_done
);
  localparam int QPTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int CNT_W  = LEN_W + $clog2(SEQ_LAT + 1) + 1;
  localparam logic [CNT_W-1:0]  LAT_C = CNT_W'(SEQ_LAT);
  localparam logic [QCNT_W-1:0] QFULL = QCNT_W'(QDEPTH);

  localparam logic [1:0] IN_RD = 2'b00, IN_WR = 2'b01, IN_TD = 2'b10;
  localparam logic [1:0] OUT_SETUP = 2'b01, OUT_ACK = 2'b10, OUT_TEAR = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_RPREP, S_RSETUP, S_RWAIT, S_RISSUE, S_RRUN,
    S_WISSUE, S_WCMD, S_WACK, S_WDATA
  } st_t;

  st_t st_q;
  logic [CORE_W-1:0] cur_core;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic              cur_wr;
  logic [CNT_W-1:0]  cnt_q;

  logic [CORE_W-1:0] q_core [QDEPTH];
  logic [ADDR_W-1:0] q_addr [QDEPTH];
  logic [LEN_W-1:0]  q_len  [QDEPTH];
  logic [QPTR_W-1:0] rd_ptr, wr_ptr;
  logic [QCNT_W-1:0] q_cnt;

  wire q_full  = (q_cnt == QFULL);
  wire q_empty = (q_cnt == '0);
  wire in_rd   = msg_in_valid && msg_in_kind == IN_RD;
  wire in_wr   = msg_in_valid && msg_in_kind == IN_WR;
  wire in_td   = msg_in_valid && msg_in_kind == IN_TD;
  wire push    = in_rd && !q_full;
  wire pop     = (st_q == S_IDLE) && !q_empty;
  wire wr_take = in_wr && (st_q == S_IDLE) && q_empty;
  wire [CNT_W-1:0] rd_end = LAT_C + CNT_W'(cur_len);
  wire rd_last = (st_q == S_RRUN) && (cnt_q == rd_end);

  assign blk_valid = (in_rd && q_full) || (in_wr && !wr_take);
  assign blk_core  = msg_in_core;

  always_comb begin
    case (st_q)
      S_RPREP, S_WISSUE, S_WCMD:         sw_sel = 2'b01;
      S_RSETUP, S_RWAIT, S_RISSUE, S_RRUN: sw_sel = 2'b10;
      S_WACK, S_WDATA:                   sw_sel = 2'b11;
      default:                           sw_sel = 2'b00;
    endcase
  end

  assign msg_out_valid = (st_q == S_RSETUP) || (st_q == S_WACK) || rd_last;
  assign msg_out_kind  = (st_q == S_RSETUP) ? OUT_SETUP :
                         (st_q == S_WACK)   ? OUT_ACK   : OUT_TEAR;
  assign msg_out_core  = cur_core;

  assign seq_start = (st_q == S_RISSUE) || (st_q == S_WISSUE);
  assign seq_write = cur_wr;
  assign seq_addr  = cur_addr;
  assign seq_len   = cur_len;

  function automatic logic [QPTR_W-1:0] nxt(input logic [QPTR_W-1:0] p);
    return (p == QPTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      q_cnt <= q_cnt + QCNT_W'(push) - QCNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_core[wr_ptr] <= msg_in_core;
      q_addr[wr_ptr] <= msg_in_addr;
      q_len[wr_ptr]  <= msg_in_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cur_core <= '0;
      cur_addr <= '0;
      cur_len  <= '0;
      cur_wr   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (pop) begin
            cur_core <= q_core[rd_ptr];
            cur_addr <= q_addr[rd_ptr];
            cur_len  <= q_len[rd_ptr];
            cur_wr   <= 1'b0;
            st_q     <= S_RPREP;
          end else if (wr_take) begin
            cur_core <= msg_in_core;
            cur_addr <= msg_in_addr;
            cur_len  <= msg_in_len;
            cur_wr   <= 1'b1;
            st_q     <= S_WISSUE;
          end
        end
        S_RPREP:  st_q <= S_RSETUP;
        S_RSETUP: st_q <= S_RWAIT;
        S_RWAIT: begin
          if (path_resp_valid) st_q <= path_resp_ok ? S_RISSUE : S_RSETUP;
        end
        S_RISSUE: begin
          cnt_q <= CNT_W'(1);
          st_q  <= S_RRUN;
        end
        S_RRUN: begin
          if (rd_last) st_q <= S_IDLE;
          else         cnt_q <= cnt_q + 1'b1;
        end
        S_WISSUE: st_q <= S_WCMD;
        S_WCMD:   if (seq_done) st_q <= S_WACK;
        S_WACK:   st_q <= S_WDATA;
        S_WDATA:  if (in_td && msg_in_core == cur_core) st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QFULL);

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && q_full) |-> (blk_valid && blk_core == msg_in_core));

  a_r4_busy_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && sw_sel != 2'b00) |-> blk_valid);

  a_r5_route_order: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_sel == 2'b10) |-> ($past(sw_sel) != 2'b00));

  a_r6_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !seq_write) |-> $past(path_resp_valid && path_resp_ok));

  a_r7_teardown_on_return_path: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_kind == OUT_TEAR) |-> (sw_sel == 2'b10 && $past(sw_sel) == 2'b10));

  a_r8_ack_after_commands: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_kind == OUT_ACK) |-> (sw_sel == 2'b11 && $past(sw_sel) == 2'b01 && $past(seq_done)));

  a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sw_sel) != 2'b00) && sw_sel == 2'b01) |-> ($past(sw_sel) == 2'b01));
endmodule

// File: tb/map_arbiter_tb_top.sv
module map_arbiter_tb_top;
  localparam int CW = 4, AW = 12, LW = 6, QD = 4, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          mi_v = 0, pr_v = 0, pr_ok = 0, sdone = 0;
  logic [1:0]    mi_k = 0;
  logic [CW-1:0] mi_c = 0;
  logic [AW-1:0] mi_a = 0;
  logic [LW-1:0] mi_l = 0;
  logic          mo_v, bv, sst, swr;
  logic [1:0]    mo_k, sel;
  logic [CW-1:0] mo_c, bc;
  logic [AW-1:0] sa;
  logic [LW-1:0] sl;

  map_arbiter #(.CORE_W(CW), .ADDR_W(AW), .LEN_W(LW), .QDEPTH(QD), .SEQ_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_in_valid(mi_v), .msg_in_kind(mi_k), .msg_in_core(mi_c), .msg_in_addr(mi_a), .msg_in_len(mi_l),
    .msg_out_valid(mo_v), .msg_out_kind(mo_k), .msg_out_core(mo_c),
    .blk_valid(bv), .blk_core(bc),
    .path_resp_valid(pr_v), .path_resp_ok(pr_ok),
    .sw_sel(sel), .seq_start(sst), .seq_write(swr), .seq_addr(sa), .seq_len(sl), .seq_done(sdone));

  typedef struct {int core; int addr; int len; bit wr;} job_t;
  job_t pend[$];
  job_t job;
  int ph = 0, cnt = 0, wcyc = 0, fails_left = 0;
  int checks = 0, errors = 0;
  bit finished = 0;
  localparam int IDLE = 0, RPREP = 1, RSET = 2, RWAIT = 3, RISS = 4, RRUN = 5,
                 WISS = 6, WCMD = 7, WACK = 8, WDATA = 9;

  function automatic string tag_of(int p);
    case (p)
      RPREP, RSET: return "R5";
      RWAIT, RISS: return "R6";
      RRUN:        return "R7";
      WISS, WCMD, WACK: return "R8";
      WDATA:       return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic chk(string r, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp_v, $time);
    end
  endtask

  task automatic compare();
    int e_sel, e_mv, e_mk, e_bv, e_st;
    string t;
    t = tag_of(ph);
    if (!rst_n) begin
      chk("R1", sel, 0, "sel"); chk("R1", mo_v, 0, "msg_out_valid");
      chk("R1", bv, 0, "blk_valid"); chk("R1", sst, 0, "seq_start");
      return;
    end
    case (ph)
      RPREP, WISS, WCMD: e_sel = 1;
      RSET, RWAIT, RISS, RRUN: e_sel = 2;
      WACK, WDATA: e_sel = 3;
      default: e_sel = 0;
    endcase
    e_mv = 0; e_mk = 0;
    if (ph == RSET) begin e_mv = 1; e_mk = 1; end
    if (ph == WACK) begin e_mv = 1; e_mk = 2; end
    if (ph == RRUN && cnt == LAT + job.len) begin e_mv = 1; e_mk = 3; end
    e_bv = 0;
    if (mi_v && mi_k == 2'b00 && pend.size() == QD) e_bv = 1;
    if (mi_v && mi_k == 2'b01 && !(ph == IDLE && pend.size() == 0)) e_bv = 1;
    e_st = (ph == RISS || ph == WISS);
    chk(t, sel, e_sel, "sw_sel");
    chk(t, mo_v, e_mv, "msg_out_valid");
    if (e_mv) begin
      chk(t, mo_k, e_mk, "msg_out_kind");
      chk("R2", mo_c, job.core, "msg_out_core");
    end
    chk((mi_k == 2'b00) ? "R3" : "R4", bv, e_bv, "blk_valid");
    if (e_bv) chk((mi_k == 2'b00) ? "R3" : "R4", bc, mi_c, "blk_core");
    chk(t, sst, e_st, "seq_start");
    if (e_st) begin
      chk(t, swr, job.wr, "seq_write");
      chk("R2", sa, job.addr, "seq_addr");
      chk("R2", sl, job.len, "seq_len");
    end
  endtask

  task automatic step();
    bit full;
    full = (pend.size() == QD);
    if (!rst_n) begin ph = IDLE; pend.delete(); return; end
    case (ph)
      IDLE: begin
        if (pend.size() > 0) begin job = pend.pop_front(); ph = RPREP; end
        else if (mi_v && mi_k == 2'b01) begin
          job.core = mi_c; job.addr = mi_a; job.len = mi_l; job.wr = 1; ph = WISS;
        end
      end
      RPREP: ph = RSET;
      RSET:  ph = RWAIT;
      RWAIT: if (pr_v) begin
               if (pr_ok) ph = RISS; else begin ph = RSET; fails_left--; end
             end
      RISS:  begin cnt = 1; ph = RRUN; end
      RRUN:  if (cnt == LAT + job.len) ph = IDLE; else cnt++;
      WISS:  begin wcyc = 0; ph = WCMD; end
      WCMD:  if (sdone) ph = WACK; else wcyc++;
      WACK:  ph = WDATA;
      WDATA: if (mi_v && mi_k == 2'b10 && mi_c == job.core) ph = IDLE;
      default: ph = IDLE;
    endcase
    if (mi_v && mi_k == 2'b00 && !full) begin
      job_t n; n.core = mi_c; n.addr = mi_a; n.len = mi_l; n.wr = 0;
      pend.push_back(n);
    end
  endtask

  task automatic cyc(bit v, int k, int c, int a, int l);
    @(negedge clk);
    mi_v = v; mi_k = 2'(k); mi_c = CW'(c); mi_a = AW'(a); mi_l = LW'(l);
    pr_v = (ph == RWAIT); pr_ok = (fails_left == 0);
    sdone = (ph == WCMD && wcyc >= 2);
    #1 compare();
    @(posedge clk);
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    cyc(1, 0, 2, 'h100, 4);                      // R2 R5 R7 plain read
    idle(20);
    fails_left = 2;
    cyc(1, 0, 7, 'h2a0, 3);                      // R6 two refusals
    idle(24);
    cyc(1, 1, 3, 'h040, 8);                      // R8 write
    idle(8);
    cyc(1, 2, 5, 0, 0);                          // R9 foreign teardown ignored
    idle(2);
    cyc(1, 2, 3, 0, 0);                          // R9 own teardown
    idle(3);
    cyc(1, 2, 3, 0, 0);                          // R9 stray teardown in idle
    cyc(1, 0, 1, 'h011, 2);                      // R3 fill queue while busy
    for (int i = 0; i < 6; i++) cyc(1, 0, 8 + i, 'h300 + i, i + 1);
    cyc(1, 1, 6, 'h555, 1);                      // R4 write while busy
    while (!(ph == RRUN && cnt == LAT + job.len)) cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 9, 'h777, 2);                      // R4 write in teardown cycle
    idle(120);                                   // R10 drain queue
    cyc(1, 0, 4, 'h0aa, 1);
    cyc(1, 1, 12, 'h0bb, 1);                     // R4 idle but queue not empty
    idle(30);
    cyc(1, 1, 12, 'h0cc, 0);                     // R8 write accepted when idle
    idle(8);
    cyc(1, 2, 12, 0, 0);
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule